// File: doc/BRIEF.md
# DMA Memory Channel Controller

This block lets an external DMA engine move bytes into or out of a small on-chip RAM without CPU help. The CPU programs a first address, a final address, a direction and a request style through a short register port. It then sets a go bit. From that point the block asks for service on a request output. When the DMA engine acknowledges, the block treats a rising read or write strobe as one byte moved at the internal address counter.

There are two request styles. In single-byte style the request drops while each acknowledge is held and comes back between bytes. In burst style the request stays high for the whole range. A transfer ends in one of two ways: it reaches the final address, or, in the write direction, the DMA side marks a byte as the last one. Both endings set a two-bit status code and pulse an interrupt. The counter is left pointing at the last address touched, so the CPU can read it back.

An acknowledge that arrives together with a CPU chip select and a high address bit would open two channels at once. The block flags this case in a sticky error bit and refuses the access. A small selector routes one of three signals to a shared output pin: transmit ready, receive ready or the request itself. All strobe and select inputs are synchronised in the system clock domain before use.

Top module: `dma_memchan`

## Requirements
- R1: After reset, `mem_req`, `irq` and `pin_out` (with selector 0 and `tx_ready` low) are 0. The status field, error bit and counter read back as 0.
- R2: The register map is: offset 0 first address, 1 final address, 2 mode, 3 status, 4 counter. Mode bits are: bit0 go, bit1 direction (1 = DMA side writes into RAM), bit2 burst, bits 4:3 pin selector. Status bits are: 1:0 status code, bit2 clash error. Writing mode with bit0 set loads the counter with the first address and makes the status code 2'b01 (busy).
- R3: In single-byte style, `mem_req` is high while busy and no acknowledge is seen. It is low while an acknowledge is held, and it is high again between bytes.
- R4: In burst style, `mem_req` stays high for as long as the transfer is busy, including while an acknowledge is held.
- R5: A byte is moved only on a rising edge of the strobe that matches the direction while `chan_ack_n` is low. A write stores `dbus_in` at the counter address. A read presents the RAM word at the counter on `dbus_out`. The counter then advances by one. A strobe of the other direction does nothing.
- R6: A byte moved at the final address sets the status code to 2'b10. It drops `mem_req`, leaves the counter at the final address and gives exactly one `irq` pulse.
- R7: A write byte with `xfer_last` high ends the transfer even before the final address. It sets the status code to 2'b11, leaves the counter at that byte's address and gives exactly one `irq` pulse. This ending takes priority over R6 when both fall on the same byte.
- R8: `xfer_last` has no effect on a read transfer.
- R9: Acknowledge low, `cpu_cs_n` low and `addr_lsb` high together set the sticky clash error bit. The strobe of that byte moves nothing: the counter and RAM are unchanged. Any write to offset 3 clears the bit.
- R10: `pin_out` follows `tx_ready` for selector 0, `rx_ready` for selector 1 and `mem_req` for selectors 2 and 3.
- R11: A strobe while `chan_ack_n` is high does not move a byte and does not advance the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_we | input | 1 | CPU register write enable |
| cpu_addr | input | 3 | CPU register offset |
| cpu_wdata | input | 8 | CPU register write data |
| cpu_rdata | output | 8 | CPU register read data (combinational) |
| chan_ack_n | input | 1 | Active-low DMA acknowledge |
| cpu_cs_n | input | 1 | Active-low CPU chip select, used for clash detection |
| addr_lsb | input | 1 | CPU address bit 0, used for clash detection |
| rd_stb_n | input | 1 | Active-low read strobe, asynchronous |
| wr_stb_n | input | 1 | Active-low write strobe, asynchronous |
| xfer_last | input | 1 | Marks the current write byte as the final one |
| dbus_in | input | 8 | Data from the DMA side |
| dbus_out | output | 8 | RAM word at the counter address |
| tx_ready | input | 1 | Transmit-ready source for the pin selector |
| rx_ready | input | 1 | Receive-ready source for the pin selector |
| mem_req | output | 1 | DMA request |
| irq | output | 1 | One-cycle completion interrupt |
| pin_out | output | 1 | Selected shared output |

## Verification
The end of the range and the last-byte mark can land on the same write strobe. The bench provokes this with a transfer whose final byte also carries `xfer_last`, and expects status 2'b11 with a single interrupt. It judges the result from the status register, the counter and an interrupt count. A clash can also coincide with a strobe edge of a live transfer. The bench drives a complete byte with the clash pattern and expects the error bit set, an unchanged counter and, later, the old RAM word read back through a read transfer.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] OFF_FIRST = 3'd0;
    localparam logic [REG_AW-1:0] OFF_FINAL = 3'd1;
    localparam logic [REG_AW-1:0] OFF_MODE  = 3'd2;
    localparam logic [REG_AW-1:0] OFF_STAT  = 3'd3;
    localparam logic [REG_AW-1:0] OFF_CNT   = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_BUSY = 2'b01,
        ST_DONE = 2'b10,
        ST_TERM = 2'b11
    } status_e;

    typedef enum logic [1:0] {
        PS_TX   = 2'b00,
        PS_RX   = 2'b01,
        PS_REQ  = 2'b10,
        PS_REQB = 2'b11
    } pin_sel_e;

    // sampled external bus, order fixes the reset pattern below
    typedef struct packed {
        logic last;
        logic a0;
        logic cs_n;
        logic ack_n;
        logic wr_n;
        logic rd_n;
    } bus_smp_t;

    localparam bus_smp_t BUS_IDLE = '{last: 1'b0, a0: 1'b0, cs_n: 1'b1,
                                      ack_n: 1'b1, wr_n: 1'b1, rd_n: 1'b1};
endpackage

// File: rtl/dmc_sync.sv
module dmc_sync #(
    parameter int          W       = 6,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_sync,
    output logic [W-1:0] q_prev
);
    localparam int LAST = STAGES;

    logic [W-1:0] stg_d [0:LAST];
    logic [W-1:0] stg_q [0:LAST];

    always_comb begin
        stg_d[0] = d_in;
        for (int i = 1; i <= LAST; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g <= LAST; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign q_sync = stg_q[LAST-1];
    assign q_prev = stg_q[LAST];
endmodule

// File: rtl/dmc_ram.sv
module dmc_ram #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [0:DEPTH-1];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/dmc_seq.sv
module dmc_seq
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              go_wr,
    input  logic              go_burst,
    input  logic [ADDR_W-1:0] go_first,
    input  logic [ADDR_W-1:0] go_final,
    input  logic              err_clr,
    input  bus_smp_t          smp,
    input  bus_smp_t          prv,
    output status_e           status,
    output logic [ADDR_W-1:0] cnt,
    output logic              req,
    output logic              irq,
    output logic              err,
    output logic              ram_we
);
    typedef struct packed {
        status_e           status;
        logic [ADDR_W-1:0] cnt;
        logic [ADDR_W-1:0] stop;
        logic              wr;
        logic              burst;
        logic              req;
        logic              irq;
        logic              err;
    } seq_t;

    localparam seq_t SEQ_RST = '{status: ST_IDLE, cnt: '0, stop: '0, wr: 1'b0,
                                 burst: 1'b0, req: 1'b0, irq: 1'b0, err: 1'b0};

    seq_t seq_d, seq_q;

    logic busy, rd_rise, wr_rise, picked, clash_prv, clash_now, stb_rise;
    logic acc, take_last;

    always_comb begin
        busy      = (seq_q.status == ST_BUSY);
        rd_rise   = smp.rd_n & ~prv.rd_n;
        wr_rise   = smp.wr_n & ~prv.wr_n;
        picked    = ~prv.ack_n;
        clash_prv = ~prv.ack_n & ~prv.cs_n & prv.a0;
        clash_now = ~smp.ack_n & ~smp.cs_n & smp.a0;
        stb_rise  = seq_q.wr ? wr_rise : rd_rise;
        acc       = busy & picked & ~clash_prv & stb_rise & ~go;
        take_last = acc & seq_q.wr & prv.last;
        ram_we    = acc & seq_q.wr;

        seq_d     = seq_q;
        seq_d.irq = 1'b0;

        if (err_clr)   seq_d.err = 1'b0;
        if (clash_now) seq_d.err = 1'b1;

        if (go) begin
            seq_d.status = ST_BUSY;
            seq_d.cnt    = go_first;
            seq_d.stop   = go_final;
            seq_d.wr     = go_wr;
            seq_d.burst  = go_burst;
        end else if (acc) begin
            if (take_last) begin
                seq_d.status = ST_TERM;
                seq_d.irq    = 1'b1;
            end else if (seq_q.cnt == seq_q.stop) begin
                seq_d.status = ST_DONE;
                seq_d.irq    = 1'b1;
            end else begin
                seq_d.cnt = seq_q.cnt + 1'b1;
            end
        end

        seq_d.req = (seq_d.status == ST_BUSY) & (seq_d.burst | smp.ack_n);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_RST;
        else        seq_q <= seq_d;
    end

    assign status = seq_q.status;
    assign cnt    = seq_q.cnt;
    assign req    = seq_q.req;
    assign irq    = seq_q.irq;
    assign err    = seq_q.err;

    a_r3_no_req_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.status != ST_BUSY) |-> !seq_q.req);

    a_r4_burst_holds_req: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.status == ST_BUSY && seq_q.burst) |-> seq_q.req);

    a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !go) |=> (seq_q.cnt == $past(seq_q.cnt) ||
                           seq_q.cnt == $past(seq_q.cnt) + 1'b1));

    a_r6_irq_on_end: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.irq |-> (seq_q.status == ST_DONE || seq_q.status == ST_TERM));

    a_r7_last_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && seq_q.wr && prv.last) |=> (seq_q.status == ST_TERM && seq_q.irq));

    a_r9_clash_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !go && clash_prv) |=> ($stable(seq_q.cnt) && seq_q.status == ST_BUSY));

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.err && !err_clr) |=> seq_q.err);

    a_r11_no_ack_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !go && prv.ack_n) |=> $stable(seq_q.cnt));
endmodule

// File: rtl/dma_memchan.sv
module dma_memchan
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic [REG_AW-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              chan_ack_n,
    input  logic              cpu_cs_n,
    input  logic              addr_lsb,
    input  logic              rd_stb_n,
    input  logic              wr_stb_n,
    input  logic              xfer_last,
    input  logic [DATA_W-1:0] dbus_in,
    output logic [DATA_W-1:0] dbus_out,
    input  logic              tx_ready,
    input  logic              rx_ready,
    output logic              mem_req,
    output logic              irq,
    output logic              pin_out
);
    localparam int BUS_W = $bits(bus_smp_t);

    typedef struct packed {
        logic [ADDR_W-1:0] first;
        logic [ADDR_W-1:0] final_a;
        logic              wr;
        logic              burst;
        pin_sel_e          psel;
    } reg_t;

    localparam reg_t REG_RST = '{first: '0, final_a: '0, wr: 1'b0, burst: 1'b0, psel: PS_TX};

    reg_t reg_d, reg_q;

    bus_smp_t          bus_raw, smp, prv;
    status_e           st;
    logic [ADDR_W-1:0] cnt;
    logic              err, ram_we, go, err_clr;

    assign bus_raw = '{last: xfer_last, a0: addr_lsb, cs_n: cpu_cs_n,
                       ack_n: chan_ack_n, wr_n: wr_stb_n, rd_n: rd_stb_n};

    dmc_sync #(
        .W      (BUS_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(BUS_IDLE)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (bus_raw),
        .q_sync(smp),
        .q_prev(prv)
    );

    // register port
    always_comb begin
        reg_d   = reg_q;
        go      = 1'b0;
        err_clr = 1'b0;
        if (cpu_we) begin
            unique case (cpu_addr)
                OFF_FIRST: reg_d.first   = cpu_wdata[ADDR_W-1:0];
                OFF_FINAL: reg_d.final_a = cpu_wdata[ADDR_W-1:0];
                OFF_MODE: begin
                    reg_d.wr    = cpu_wdata[1];
                    reg_d.burst = cpu_wdata[2];
                    reg_d.psel  = pin_sel_e'(cpu_wdata[4:3]);
                    go          = cpu_wdata[0];
                end
                OFF_STAT:  err_clr = 1'b1;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= REG_RST;
        else        reg_q <= reg_d;
    end

    always_comb begin
        cpu_rdata = '0;
        unique case (cpu_addr)
            OFF_FIRST: cpu_rdata = DATA_W'(reg_q.first);
            OFF_FINAL: cpu_rdata = DATA_W'(reg_q.final_a);
            OFF_MODE:  cpu_rdata = DATA_W'({reg_q.psel, reg_q.burst, reg_q.wr, 1'b0});
            OFF_STAT:  cpu_rdata = DATA_W'({err, st});
            OFF_CNT:   cpu_rdata = DATA_W'(cnt);
            default:   cpu_rdata = '0;
        endcase
    end

    dmc_seq #(
        .ADDR_W(ADDR_W)
    ) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .go_wr   (cpu_wdata[1]),
        .go_burst(cpu_wdata[2]),
        .go_first(reg_q.first),
        .go_final(reg_q.final_a),
        .err_clr (err_clr),
        .smp     (smp),
        .prv     (prv),
        .status  (st),
        .cnt     (cnt),
        .req     (mem_req),
        .irq     (irq),
        .err     (err),
        .ram_we  (ram_we)
    );

    dmc_ram #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) i_ram (
        .clk  (clk),
        .we   (ram_we),
        .waddr(cnt),
        .wdata(dbus_in),
        .raddr(cnt),
        .rdata(dbus_out)
    );

    always_comb begin
        unique case (reg_q.psel)
            PS_TX:   pin_out = tx_ready;
            PS_RX:   pin_out = rx_ready;
            default: pin_out = mem_req;
        endcase
    end

    a_r10_pin_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_q.psel == PS_REQ || reg_q.psel == PS_REQB) |-> (pin_out == mem_req));

    a_r8_read_never_term: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUSY && !reg_q.wr && !go) |=> (st != ST_TERM));
endmodule

// File: tb/test_dma_memchan.sv
`timescale 1ns/1ps
module test_dma_memchan;
    import dmc_pkg::*;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       cpu_we = 1'b0;
    logic [2:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0, cpu_rdata, dbus_in = '0, dbus_out;
    logic       chan_ack_n = 1'b1, cpu_cs_n = 1'b1, addr_lsb = 1'b0;
    logic       rd_stb_n = 1'b1, wr_stb_n = 1'b1, xfer_last = 1'b0;
    logic       tx_ready = 1'b0, rx_ready = 1'b0;
    logic       mem_req, irq, pin_out;

    int n_run = 0, n_fail = 0, irq_seen = 0;

    always #10 clk = ~clk;

    dma_memchan i_dma_memchan (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .chan_ack_n(chan_ack_n),
        .cpu_cs_n(cpu_cs_n), .addr_lsb(addr_lsb), .rd_stb_n(rd_stb_n),
        .wr_stb_n(wr_stb_n), .xfer_last(xfer_last), .dbus_in(dbus_in),
        .dbus_out(dbus_out), .tx_ready(tx_ready), .rx_ready(rx_ready),
        .mem_req(mem_req), .irq(irq), .pin_out(pin_out)
    );

    always @(negedge clk) if (rst_n && irq) irq_seen++;

    typedef struct packed {
        logic [5:0] first;
        logic [5:0] fin;
        logic       burst;
        logic [3:0] last_idx;
        logic [3:0] nbytes;
        logic [1:0] stat;
        logic [5:0] cnt;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{6'd2,  6'd5,  1'b0, 4'd15, 4'd4, 2'b10, 6'd5},
        '{6'd10, 6'd13, 1'b1, 4'd1,  4'd2, 2'b11, 6'd11},
        '{6'd20, 6'd21, 1'b0, 4'd1,  4'd2, 2'b11, 6'd21},
        '{6'd30, 6'd35, 1'b1, 4'd0,  4'd1, 2'b11, 6'd30},
        '{6'd50, 6'd50, 1'b1, 4'd15, 4'd1, 2'b10, 6'd50}
    };

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cpu_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic cpu_rd(input logic [2:0] a, output logic [7:0] d);
        cpu_addr = a;
        #1;
        d = cpu_rdata;
    endtask

    // mode: {3'b0, psel[1:0], burst, wr, go}
    task automatic start_xfer(input logic [5:0] f, input logic [5:0] l,
                              input logic wr, input logic burst);
        cpu_wr(OFF_FIRST, {2'b00, f});
        cpu_wr(OFF_FINAL, {2'b00, l});
        cpu_wr(OFF_MODE, {3'b000, 2'b10, burst, wr, 1'b1});
    endtask

    task automatic do_byte(input logic wr, input logic [7:0] d, input logic lst,
                           input logic csn, input logic a0v, input logic ack,
                           output logic [7:0] rdv, output logic reqm);
        @(negedge clk);
        chan_ack_n = ~ack; cpu_cs_n = csn; addr_lsb = a0v; xfer_last = lst; dbus_in = d;
        repeat (2) @(negedge clk);
        if (wr) wr_stb_n = 1'b0; else rd_stb_n = 1'b0;
        repeat (3) @(negedge clk);
        reqm = mem_req;
        rdv  = dbus_out;
        if (wr) wr_stb_n = 1'b1; else rd_stb_n = 1'b1;
        repeat (4) @(negedge clk);
        chan_ack_n = 1'b1; cpu_cs_n = 1'b1; addr_lsb = 1'b0; xfer_last = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        logic       rq;
        int         irq0;

        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 mem_req", mem_req, 0);
        check("R1 irq", irq, 0);
        check("R1 pin_out", pin_out, 0);
        cpu_rd(OFF_STAT, rv); check("R1 status", rv, 0);
        cpu_rd(OFF_CNT, rv);  check("R1 counter", rv, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // write transfers from the vector table
        for (int v = 0; v < 5; v++) begin
            irq0 = irq_seen;
            start_xfer(VEC[v].first, VEC[v].fin, 1'b1, VEC[v].burst);
            cpu_rd(OFF_CNT, rv);  check("R2 load counter", rv, VEC[v].first);
            cpu_rd(OFF_STAT, rv); check("R2 busy", rv, 1);
            check("R3 R4 request up", mem_req, 1);
            check("R10 pin shows request", pin_out, 1);
            for (int b = 0; b < VEC[v].nbytes; b++) begin
                do_byte(1'b1, 8'(VEC[v].first + b) ^ 8'h5A, (b == VEC[v].last_idx),
                        1'b1, 1'b0, 1'b1, rv, rq);
                if (VEC[v].burst) check("R4 request held in ack", rq, 1);
                else              check("R3 request low in ack", rq, 0);
                if (b < VEC[v].nbytes - 1) begin
                    check("R3 R4 request between bytes", mem_req, 1);
                    cpu_rd(OFF_CNT, rv); check("R5 counter step", rv, VEC[v].first + b + 1);
                end
            end
            cpu_rd(OFF_STAT, rv);
            if (VEC[v].stat == 2'b11) check("R7 term status", rv, 3);
            else                      check("R6 done status", rv, 2);
            cpu_rd(OFF_CNT, rv);
            if (VEC[v].stat == 2'b11) check("R7 last address", rv, VEC[v].cnt);
            else                      check("R6 final address", rv, VEC[v].cnt);
            check("R6 request dropped", mem_req, 0);
            check("R6 R7 one irq", irq_seen - irq0, 1);
        end

        // read back 2..5 with xfer_last asserted on the first byte
        irq0 = irq_seen;
        start_xfer(6'd2, 6'd5, 1'b0, 1'b0);
        for (int b = 0; b < 4; b++) begin
            do_byte(1'b0, 8'h00, (b == 0), 1'b1, 1'b0, 1'b1, rv, rq);
            check("R5 read data", rv, 8'(2 + b) ^ 8'h5A);
            if (b == 0) begin
                cpu_rd(OFF_STAT, rv); check("R8 last ignored on read", rv, 1);
                cpu_rd(OFF_CNT, rv);  check("R8 counter moves on", rv, 3);
            end
        end
        cpu_rd(OFF_STAT, rv); check("R8 read ends normally", rv, 2);
        check("R6 read one irq", irq_seen - irq0, 1);

        // clash: seed 0x33 at 40, then try to overwrite under a clash
        start_xfer(6'd40, 6'd40, 1'b1, 1'b0);
        do_byte(1'b1, 8'h33, 1'b0, 1'b1, 1'b0, 1'b1, rv, rq);
        start_xfer(6'd40, 6'd41, 1'b1, 1'b0);
        cpu_rd(OFF_STAT, rv); check("R9 err clear before", rv, 1);
        do_byte(1'b1, 8'hEE, 1'b0, 1'b0, 1'b1, 1'b1, rv, rq);
        cpu_rd(OFF_STAT, rv); check("R9 err set, still busy", rv, 5);
        cpu_rd(OFF_CNT, rv);  check("R9 counter blocked", rv, 40);
        repeat (3) @(negedge clk);
        cpu_rd(OFF_STAT, rv); check("R9 err sticky", rv[2], 1);
        cpu_wr(OFF_STAT, 8'h00);
        cpu_rd(OFF_STAT, rv); check("R9 err cleared", rv[2], 0);
        start_xfer(6'd40, 6'd40, 1'b0, 1'b0);
        do_byte(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, rv, rq);
        check("R9 ram unchanged", rv, 8'h33);

        // strobe without acknowledge, and strobe of the wrong direction
        start_xfer(6'd44, 6'd45, 1'b1, 1'b0);
        do_byte(1'b1, 8'h11, 1'b0, 1'b1, 1'b0, 1'b0, rv, rq);
        cpu_rd(OFF_CNT, rv);  check("R11 no ack no step", rv, 44);
        do_byte(1'b0, 8'h11, 1'b0, 1'b1, 1'b0, 1'b1, rv, rq);
        cpu_rd(OFF_CNT, rv);  check("R5 wrong strobe ignored", rv, 44);
        cpu_rd(OFF_STAT, rv); check("R11 still busy", rv, 1);
        do_byte(1'b1, 8'h21, 1'b0, 1'b1, 1'b0, 1'b1, rv, rq);
        do_byte(1'b1, 8'h22, 1'b0, 1'b1, 1'b0, 1'b1, rv, rq);
        cpu_rd(OFF_STAT, rv); check("R6 done after valid bytes", rv, 2);
        cpu_rd(OFF_CNT, rv);  check("R6 counter at final", rv, 45);

        // pin selector
        cpu_wr(OFF_MODE, {3'b000, 2'b00, 3'b000});
        tx_ready = 1'b1; rx_ready = 1'b0; #1;
        check("R10 sel0 tx high", pin_out, 1);
        tx_ready = 1'b0; #1;
        check("R10 sel0 tx low", pin_out, 0);
        cpu_wr(OFF_MODE, {3'b000, 2'b01, 3'b000});
        rx_ready = 1'b1; #1;
        check("R10 sel1 rx", pin_out, 1);
        cpu_wr(OFF_MODE, {3'b000, 2'b11, 3'b000});
        #1;
        check("R10 sel3 idle request", pin_out, 0);
        cpu_rd(OFF_STAT, rv); check("R2 mode without go keeps status", rv, 2);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule